// File: doc/BRIEF.md
# Depth-Cued Normal Color Pipeline

This block lights one vertex normal and depth-cues the result. After a start pulse it steps through a fixed sequence of fixed-point stages:

- The normal is transformed by a light matrix.
- That result is transformed by a color matrix and offset by a background color.
- Each channel is tinted by a base RGB color.
- The distance to a far color is formed.
- The channel is interpolated toward the far color by a depth factor.

The final value of each channel is divided by 16, clamped to a byte and pushed with a code byte into a three-entry color queue. The three accumulator (MAC) and intermediate (IR) values are visible after every stage. Flags gather every saturation that occurred during the run.

The lighting register set arrives on ports and must stay stable while `busy` is high. The normal, `sf` (fractional shift select) and `lm` (lower IR limit of zero) are captured when the start is accepted.

The controller has seven states:

- IDLE goes to LIGHT when `start` is high.
- LIGHT goes to COLOR, COLOR to TINT, TINT to FAR, FAR to BLEND and BLEND to PUSH, one clock each.
- PUSH always returns to IDLE.

Top module: `ncd_light_seq`

## Requirements
- R1: Reset clears every MAC, IR, queue slot and flag to zero, and holds `busy` and `done` low.
- R2: A start is accepted only while idle. `busy` is high for the six clocks after the accepting edge. `done` is high for exactly one cycle after the PUSH edge. A start raised while busy has no effect and produces no second push.
- R3: LIGHT sets MAC_i to the light matrix row i dotted with the normal, saturated, then shifted arithmetically right by 12 when `sf` is set and kept to 32 bits. IR_i takes MAC_i clamped to [lm ? 0 : -32768, 32767].
- R4: COLOR sets MAC_i to (background_i zero-extended and shifted left by 12) plus color matrix row i dotted with IR1..3. Saturation, the `sf` shift and the IR update are as in R3.
- R5: TINT sets MAC_i to (base channel_i times 16) times MAC_i, saturated, with no shift regardless of `sf`. IR is unchanged.
- R6: FAR sets IR_i to the low 32 bits of ((far_i shifted left by 12) minus MAC_i), shifted arithmetically right by 12 when `sf` is set, then clamped to [-32768, 32767] whatever `lm` is. MAC is unchanged.
- R7: BLEND sets MAC_i to IR_i times the depth factor plus MAC_i, saturated, then shifted right by 12 when `sf` is set. The depth factor port is clamped to [0, 0x1000] before use.
- R8: PUSH forms channel byte MAC_i/16, rounded toward zero and clamped to [0, 255]. The entry is laid out as bits [7:0] red, [15:8] green, [23:16] blue and [31:24] the code byte. The entry enters slot 2 (bits [95:64]), slot 2 moves to slot 1, and slot 1 moves to slot 0.
- R9: On the PUSH edge, IR_i takes the final MAC_i clamped with the captured `lm`.
- R10: The flags are laid out as [2:0] MAC over, [5:3] MAC under, [8:6] IR clamp and [11:9] byte clamp, with channel i at bit i of each group. They clear when a start is accepted and only accumulate during a run.
- R11: Before the shift, MAC saturates at 2^43-1 and -2^43 and raises the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one lighting run |
| sf | input | 1 | Shift results right by 12 |
| lm | input | 1 | Lower IR clamp at zero |
| nrm_x | input | 16 | Normal X, signed |
| nrm_y | input | 16 | Normal Y, signed |
| nrm_z | input | 16 | Normal Z, signed |
| light_mtx | input | 144 | Light matrix; element (r,c) at bits (3r+c)*16 +: 16 |
| color_mtx | input | 144 | Color matrix, same layout |
| back_col | input | 96 | Background color, channel i at i*32 +: 32, unsigned |
| far_col | input | 96 | Far color, same layout |
| base_rgbc | input | 32 | Base red [7:0], green [15:8], blue [23:16], code [31:24] |
| depth_ir0 | input | 16 | Depth factor, signed, clamped to 0..0x1000 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mac_out | output | 96 | MAC_i at i*32 +: 32 |
| ir_out | output | 48 | IR_i at i*16 +: 16 |
| flags | output | 12 | Saturation flags, see R10 |
| fifo_out | output | 96 | Color queue slot k at k*32 +: 32 |

## Verification
Each channel passes four wide intermediates, so the hardest conditions to reach from the ports are the rare ones. These include a 44-bit saturation, an FAR value whose low 32 bits wrap, and a final byte clamp in both directions. Directed runs create each of them:

- A full-scale background color with `sf` clear forces MAC saturation.
- A negative normal with `lm` set forces IR clamping at zero.
- A large background color fed through a zero depth factor drives the byte clamp high.

Random register sets then cover mixed signs. A behavioural model checks every intermediate on every clock. A restart pulse raised while busy confirms that a run cannot be re-entered.

// File: rtl/ncd_pkg.sv
package ncd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LIGHT,
        ST_COLOR,
        ST_TINT,
        ST_FAR,
        ST_BLEND,
        ST_PUSH
    } stage_e;

    localparam int NCH = 3;
endpackage

// File: rtl/ncd_ctrl.sv
module ncd_ctrl
    import ncd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sf,
    input  logic              lm,
    input  logic [3*DW-1:0]   vec_in,
    output stage_e            stage,
    output logic              busy,
    output logic              done,
    output logic              clr,
    output logic              sf_q,
    output logic              lm_q,
    output logic [3*DW-1:0]   vec_q
);
    stage_e nxt;

    always_comb begin
        nxt = stage;
        unique case (stage)
            ST_IDLE:  nxt = start ? ST_LIGHT : ST_IDLE;
            ST_LIGHT: nxt = ST_COLOR;
            ST_COLOR: nxt = ST_TINT;
            ST_TINT:  nxt = ST_FAR;
            ST_FAR:   nxt = ST_BLEND;
            ST_BLEND: nxt = ST_PUSH;
            ST_PUSH:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= ST_IDLE;
        else        stage <= nxt;
    end

    assign busy = (stage != ST_IDLE);
    assign clr  = start && (stage == ST_IDLE);

    // registered outputs and captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            sf_q  <= 1'b0;
            lm_q  <= 1'b0;
            vec_q <= '0;
        end else begin
            done <= (stage == ST_PUSH);
            if (clr) begin
                sf_q  <= sf;
                lm_q  <= lm;
                vec_q <= vec_in;
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (stage == ST_LIGHT));
    // R2
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stage != ST_PUSH) |=> busy);
endmodule

// File: rtl/ncd_lane.sv
module ncd_lane
    import ncd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int MW   = 32,
    parameter int AW   = 44,
    parameter int FR   = 12,
    parameter int CW   = 8,
    parameter int RGBW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stage_e            stage,
    input  logic              clr,
    input  logic              sf,
    input  logic              lm,
    input  logic [3*DW-1:0]   vec,
    input  logic [3*DW-1:0]   light_row,
    input  logic [3*DW-1:0]   color_row,
    input  logic [3*DW-1:0]   ir_vec,
    input  logic [MW-1:0]     back_c,
    input  logic [MW-1:0]     far_c,
    input  logic [RGBW-1:0]   base_c,
    input  logic [DW-1:0]     ir0,
    output logic [MW-1:0]     mac_q,
    output logic [DW-1:0]     ir_q,
    output logic [CW-1:0]     color,
    output logic              f_ovf,
    output logic              f_unf,
    output logic              f_irs,
    output logic              f_col
);
    localparam int WW = AW + 4;
    localparam int PW = 2 * DW;
    localparam logic signed [WW-1:0] AMAX = {{(WW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [WW-1:0] AMIN = {{(WW-AW+1){1'b1}}, {(AW-1){1'b0}}};
    localparam logic signed [MW-1:0] DIV16 = MW'(16);
    localparam logic signed [MW-1:0] CMAX  = {{(MW-CW){1'b0}}, {CW{1'b1}}};

    function automatic logic signed [WW-1:0] dot3(input logic [3*DW-1:0] a,
                                                  input logic [3*DW-1:0] b);
        logic signed [WW-1:0] acc;
        logic signed [PW-1:0] p;
        acc = '0;
        for (int j = 0; j < 3; j++) begin
            p   = $signed(a[j*DW +: DW]) * $signed(b[j*DW +: DW]);
            acc = acc + {{(WW-PW){p[PW-1]}}, p};
        end
        return acc;
    endfunction

    function automatic logic [DW:0] ir_clip(input logic signed [MW-1:0] v,
                                            input logic floor0);
        logic signed [MW-1:0] hi, lo;
        hi = {{(MW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = floor0 ? '0 : {{(MW-DW+1){1'b1}}, {(DW-1){1'b0}}};
        if (v < lo)      return {1'b1, lo[DW-1:0]};
        else if (v > hi) return {1'b1, hi[DW-1:0]};
        else             return {1'b0, v[DW-1:0]};
    endfunction

    logic signed [WW-1:0] macw, bkw, farw, rgbw, pre, satv, shv, dif;
    logic signed [PW-1:0] bprod;
    logic signed [MW-1:0] d32, dsh, quo;
    logic [MW-1:0]        mac_nx;
    logic                 acc_ovf, acc_unf, col_sat;
    logic [DW-1:0]        ir_a, ir_f, ir_p;
    logic                 irs_a, irs_f, irs_p;

    assign macw  = {{(WW-MW){mac_q[MW-1]}}, mac_q};
    assign bkw   = {{(WW-MW-FR){1'b0}}, back_c, {FR{1'b0}}};
    assign farw  = {{(WW-MW-FR){1'b0}}, far_c, {FR{1'b0}}};
    assign rgbw  = {{(WW-RGBW-4){1'b0}}, base_c, 4'b0000};
    assign bprod = $signed(ir_q) * $signed(ir0);

    // accumulator pre-value for the stage in progress
    always_comb begin
        pre = '0;
        unique case (stage)
            ST_LIGHT: pre = dot3(light_row, vec);
            ST_COLOR: pre = bkw + dot3(color_row, ir_vec);
            ST_TINT:  pre = rgbw * macw;
            ST_BLEND: pre = {{(WW-PW){bprod[PW-1]}}, bprod} + macw;
            default:  pre = '0;
        endcase
    end

    // saturation and optional fraction shift
    always_comb begin
        acc_ovf = (pre > AMAX);
        acc_unf = (pre < AMIN);
        satv    = acc_ovf ? AMAX : (acc_unf ? AMIN : pre);
        shv     = (sf && stage != ST_TINT) ? (satv >>> FR) : satv;
        mac_nx  = shv[MW-1:0];
        {irs_a, ir_a} = ir_clip(mac_nx, lm);
    end

    // far-color distance, clamped without the lower limit
    always_comb begin
        dif = farw - macw;
        d32 = dif[MW-1:0];
        dsh = sf ? (d32 >>> FR) : d32;
        {irs_f, ir_f} = ir_clip(dsh, 1'b0);
        {irs_p, ir_p} = ir_clip(mac_q, lm);
    end

    // byte conversion, rounding toward zero
    always_comb begin
        quo     = $signed(mac_q) / DIV16;
        col_sat = 1'b0;
        if (quo < 0) begin
            color   = '0;
            col_sat = 1'b1;
        end else if (quo > CMAX) begin
            color   = {CW{1'b1}};
            col_sat = 1'b1;
        end else begin
            color   = quo[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= '0;
            ir_q  <= '0;
            f_ovf <= 1'b0;
            f_unf <= 1'b0;
            f_irs <= 1'b0;
            f_col <= 1'b0;
        end else begin
            if (clr) begin
                f_ovf <= 1'b0;
                f_unf <= 1'b0;
                f_irs <= 1'b0;
                f_col <= 1'b0;
            end
            unique case (stage)
                ST_LIGHT, ST_COLOR: begin
                    mac_q <= mac_nx;
                    ir_q  <= ir_a;
                    f_ovf <= f_ovf | acc_ovf;
                    f_unf <= f_unf | acc_unf;
                    f_irs <= f_irs | irs_a;
                end
                ST_TINT, ST_BLEND: begin
                    mac_q <= mac_nx;
                    f_ovf <= f_ovf | acc_ovf;
                    f_unf <= f_unf | acc_unf;
                end
                ST_FAR: begin
                    ir_q  <= ir_f;
                    f_irs <= f_irs | irs_f;
                end
                ST_PUSH: begin
                    ir_q  <= ir_p;
                    f_irs <= f_irs | irs_p;
                    f_col <= f_col | col_sat;
                end
                default: ;
            endcase
        end
    end

    // R9
    ir_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage) == ST_PUSH && $past(lm)) |-> !ir_q[DW-1]);
    // R6
    far_keeps_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_FAR) |=> $stable(mac_q));
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != ST_IDLE && f_ovf) |=> f_ovf);
endmodule

// File: rtl/ncd_color_fifo.sv
module ncd_color_fifo #(
    parameter int DEPTH = 3,
    parameter int EW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [EW-1:0]       din,
    output logic [DEPTH*EW-1:0] slots
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        if (k == DEPTH - 1) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    slots[k*EW +: EW] <= '0;
                else if (push) slots[k*EW +: EW] <= din;
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    slots[k*EW +: EW] <= '0;
                else if (push) slots[k*EW +: EW] <= slots[(k+1)*EW +: EW];
            end
        end
    end

    // R8
    newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> slots[(DEPTH-1)*EW +: EW] == $past(din));
    // R8
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> slots[0 +: EW] == $past(slots[EW +: EW]));
endmodule

// File: rtl/ncd_light_seq.sv
module ncd_light_seq
    import ncd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int MW    = 32,
    parameter int AW    = 44,
    parameter int FR    = 12,
    parameter int CW    = 8,
    parameter int DEPTH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    sf,
    input  logic                    lm,
    input  logic [DW-1:0]           nrm_x,
    input  logic [DW-1:0]           nrm_y,
    input  logic [DW-1:0]           nrm_z,
    input  logic [9*DW-1:0]         light_mtx,
    input  logic [9*DW-1:0]         color_mtx,
    input  logic [3*MW-1:0]         back_col,
    input  logic [3*MW-1:0]         far_col,
    input  logic [4*CW-1:0]         base_rgbc,
    input  logic [DW-1:0]           depth_ir0,
    output logic                    busy,
    output logic                    done,
    output logic [3*MW-1:0]         mac_out,
    output logic [3*DW-1:0]         ir_out,
    output logic [4*NCH-1:0]        flags,
    output logic [DEPTH*4*CW-1:0]   fifo_out
);
    localparam int EW = 4 * CW;
    localparam logic signed [DW-1:0] IR0_MAX = DW'(1 << FR);

    stage_e           stage;
    logic             clr, sf_q, lm_q;
    logic [3*DW-1:0]  vec_q;
    logic [DW-1:0]    ir0_c;
    logic [CW-1:0]    col [NCH];
    logic [NCH-1:0]   f_ovf, f_unf, f_irs, f_col;

    // depth factor held inside its legal range
    always_comb begin
        if ($signed(depth_ir0) < 0)            ir0_c = '0;
        else if ($signed(depth_ir0) > IR0_MAX) ir0_c = IR0_MAX;
        else                                   ir0_c = depth_ir0;
    end

    ncd_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .sf(sf), .lm(lm),
        .vec_in({nrm_z, nrm_y, nrm_x}),
        .stage(stage), .busy(busy), .done(done), .clr(clr),
        .sf_q(sf_q), .lm_q(lm_q), .vec_q(vec_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        ncd_lane #(.DW(DW), .MW(MW), .AW(AW), .FR(FR), .CW(CW), .RGBW(CW)) u_lane (
            .clk(clk), .rst_n(rst_n), .stage(stage), .clr(clr),
            .sf(sf_q), .lm(lm_q), .vec(vec_q),
            .light_row(light_mtx[i*3*DW +: 3*DW]),
            .color_row(color_mtx[i*3*DW +: 3*DW]),
            .ir_vec(ir_out),
            .back_c(back_col[i*MW +: MW]),
            .far_c(far_col[i*MW +: MW]),
            .base_c(base_rgbc[i*CW +: CW]),
            .ir0(ir0_c),
            .mac_q(mac_out[i*MW +: MW]),
            .ir_q(ir_out[i*DW +: DW]),
            .color(col[i]),
            .f_ovf(f_ovf[i]), .f_unf(f_unf[i]), .f_irs(f_irs[i]), .f_col(f_col[i])
        );
    end

    assign flags = {f_col, f_irs, f_unf, f_ovf};

    ncd_color_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(stage == ST_PUSH),
        .din({base_rgbc[3*CW +: CW], col[2], col[1], col[0]}),
        .slots(fifo_out)
    );

    // R7
    ir0_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir0_c[DW-1] && ($signed(ir0_c) <= IR0_MAX));
endmodule

// File: tb/test_ncd_light_seq.sv
module test_ncd_light_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n, start, sf, lm;
    logic [15:0]  nrm_x, nrm_y, nrm_z, depth_ir0;
    logic [143:0] light_mtx, color_mtx;
    logic [95:0]  back_col, far_col;
    logic [31:0]  base_rgbc;
    logic         busy, done;
    logic [95:0]  mac_out;
    logic [47:0]  ir_out;
    logic [11:0]  flags;
    logic [95:0]  fifo_out;

    ncd_light_seq i_ncd_light_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sf(sf), .lm(lm),
        .nrm_x(nrm_x), .nrm_y(nrm_y), .nrm_z(nrm_z),
        .light_mtx(light_mtx), .color_mtx(color_mtx),
        .back_col(back_col), .far_col(far_col), .base_rgbc(base_rgbc),
        .depth_ir0(depth_ir0), .busy(busy), .done(done),
        .mac_out(mac_out), .ir_out(ir_out), .flags(flags), .fifo_out(fifo_out)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_mac [3];
    int          m_ir  [3];
    logic [31:0] m_fifo[3];
    logic [11:0] m_flags;
    int          m_stage, m_last;
    bit          m_done, m_sf, m_lm;
    int          m_v[3];

    localparam longint LIM_HI = (64'sd1 <<< 43) - 1;
    localparam longint LIM_LO = -(64'sd1 <<< 43);

    function automatic longint sat44(longint v, int ch);
        if (v > LIM_HI) begin m_flags[ch] = 1'b1; return LIM_HI; end
        if (v < LIM_LO) begin m_flags[3+ch] = 1'b1; return LIM_LO; end
        return v;
    endfunction

    function automatic int irsat(int v, bit floor0, int ch);
        int lo = floor0 ? 0 : -32768;
        if (v < lo)    begin m_flags[6+ch] = 1'b1; return lo; end
        if (v > 32767) begin m_flags[6+ch] = 1'b1; return 32767; end
        return v;
    endfunction

    function automatic int fin(longint t, int ch);
        longint s = sat44(t, ch);
        if (m_sf) s = s >>> 12;
        return int'(s);
    endfunction

    function automatic longint elem(logic [143:0] m, int r, int c);
        return longint'($signed(m[(r*3+c)*16 +: 16]));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int     tmp[3];
        longint t;
        int     ir0v, q, c;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_mac[i] = 0; m_ir[i] = 0; m_fifo[i] = '0; end
            m_flags = '0; m_stage = 0; m_last = 0; m_done = 0;
        end else begin
            m_done = 0;
            m_last = m_stage;
            ir0v = int'($signed(depth_ir0));
            if (ir0v < 0) ir0v = 0;
            if (ir0v > 4096) ir0v = 4096;
            case (m_stage)
                0: if (start) begin
                    m_sf = sf; m_lm = lm; m_flags = '0;
                    m_v[0] = int'($signed(nrm_x)); m_v[1] = int'($signed(nrm_y)); m_v[2] = int'($signed(nrm_z));
                    m_stage = 1;
                end
                1: begin
                    for (int ch = 0; ch < 3; ch++) begin
                        t = 0;
                        for (int j = 0; j < 3; j++) t += elem(light_mtx, ch, j) * longint'(m_v[j]);
                        tmp[ch] = fin(t, ch);
                    end
                    for (int ch = 0; ch < 3; ch++) begin m_mac[ch] = tmp[ch]; m_ir[ch] = irsat(tmp[ch], m_lm, ch); end
                    m_stage = 2;
                end
                2: begin
                    for (int ch = 0; ch < 3; ch++) begin
                        t = longint'(back_col[ch*32 +: 32]) <<< 12;
                        for (int j = 0; j < 3; j++) t += elem(color_mtx, ch, j) * longint'(m_ir[j]);
                        tmp[ch] = fin(t, ch);
                    end
                    for (int ch = 0; ch < 3; ch++) begin m_mac[ch] = tmp[ch]; m_ir[ch] = irsat(tmp[ch], m_lm, ch); end
                    m_stage = 3;
                end
                3: begin
                    for (int ch = 0; ch < 3; ch++)
                        m_mac[ch] = int'(sat44(longint'(base_rgbc[ch*8 +: 8]) * 16 * longint'(m_mac[ch]), ch));
                    m_stage = 4;
                end
                4: begin
                    for (int ch = 0; ch < 3; ch++) begin
                        c = int'((longint'(far_col[ch*32 +: 32]) <<< 12) - longint'(m_mac[ch]));
                        if (m_sf) c = c >>> 12;
                        m_ir[ch] = irsat(c, 1'b0, ch);
                    end
                    m_stage = 5;
                end
                5: begin
                    for (int ch = 0; ch < 3; ch++)
                        m_mac[ch] = fin(longint'(m_ir[ch]) * longint'(ir0v) + longint'(m_mac[ch]), ch);
                    m_stage = 6;
                end
                default: begin
                    m_fifo[0] = m_fifo[1];
                    m_fifo[1] = m_fifo[2];
                    m_fifo[2][31:24] = base_rgbc[31:24];
                    for (int ch = 0; ch < 3; ch++) begin
                        q = m_mac[ch] / 16;
                        if (q < 0)   begin q = 0;   m_flags[9+ch] = 1'b1; end
                        if (q > 255) begin q = 255; m_flags[9+ch] = 1'b1; end
                        m_fifo[2][ch*8 +: 8] = q[7:0];
                        m_ir[ch] = irsat(m_mac[ch], m_lm, ch);
                    end
                    m_done = 1; m_stage = 0;
                end
            endcase
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        string tm, ti;
        case (m_last)
            1: begin tm = "R3"; ti = "R3"; end
            2: begin tm = "R4"; ti = "R4"; end
            3: begin tm = "R5"; ti = "R5"; end
            4: begin tm = "R6"; ti = "R6"; end
            5: begin tm = "R7"; ti = "R7"; end
            6: begin tm = "R8"; ti = "R9"; end
            default: begin tm = "R1"; ti = "R1"; end
        endcase
        if (done) done_cnt++;
        check("R2", "busy", longint'(busy), longint'(m_stage != 0));
        check("R2", "done", longint'(done), longint'(m_done));
        for (int ch = 0; ch < 3; ch++) begin
            check(tm, "mac", longint'(mac_out[ch*32 +: 32]), longint'(unsigned'(m_mac[ch])));
            check(ti, "ir", longint'(ir_out[ch*16 +: 16]), longint'(m_ir[ch][15:0]));
            check("R8", "fifo", longint'(fifo_out[ch*32 +: 32]), longint'(m_fifo[ch]));
        end
        check("R10", "flags", longint'(flags), longint'(m_flags));
    end

    // ---------------- stimulus ----------------
    task automatic go();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    function automatic logic [143:0] diag(logic [15:0] d);
        logic [143:0] m = '0;
        for (int i = 0; i < 3; i++) m[(i*4)*16 +: 16] = d;
        return m;
    endfunction

    task automatic clear_regs();
        light_mtx = '0; color_mtx = '0; back_col = '0; far_col = '0;
        base_rgbc = '0; depth_ir0 = '0; nrm_x = '0; nrm_y = '0; nrm_z = '0;
        sf = 1'b0; lm = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int d0;
        rst_n = 1'b0; start = 1'b0;
        clear_regs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "rst mac", longint'(mac_out[63:0]), 0);
        check("R1", "rst fifo", longint'(fifo_out[63:0]), 0);
        check("R1", "rst ir", longint'(ir_out), 0);
        check("R1", "rst flags", longint'(flags), 0);
        check("R1", "rst busy/done", longint'({busy, done}), 0);

        // basic lighting, sf set
        light_mtx = diag(16'h1000); color_mtx = diag(16'h1000);
        nrm_x = 16'h0800; nrm_y = 16'h0400; nrm_z = 16'h0200;
        base_rgbc = 32'h5A204080; far_col = {32'h10, 32'h20, 32'h30};
        depth_ir0 = 16'h0800; sf = 1'b1;
        go();

        // R11 saturation of the accumulator with sf clear
        clear_regs();
        back_col = {3{32'hFFFF_FFFF}};
        go();
        check("R11", "over flags", longint'(flags[2:0]), 7);

        // R3 lower IR limit with lm, R9 final IR floor
        clear_regs();
        light_mtx = diag(16'h1000); sf = 1'b1; lm = 1'b1;
        nrm_x = -16'sd1024; nrm_y = -16'sd1024; nrm_z = -16'sd1024;
        go();
        check("R3", "ir clamp flags", longint'(flags[8:6]), 7);
        for (int ch = 0; ch < 3; ch++) check("R9", "final ir sign", longint'(ir_out[ch*16+15]), 0);

        // R8 byte clamp high with code byte
        clear_regs();
        back_col = {3{32'h0001_0000}}; base_rgbc = 32'hC3808080; sf = 1'b1;
        go();
        check("R8", "slot2 entry", longint'(fifo_out[95:64]), longint'(32'hC3FF_FFFF));
        check("R10", "byte clamp flags", longint'(flags[11:9]), 7);

        // R7 depth factor clamp, above and below range
        clear_regs();
        light_mtx = diag(16'h0800); color_mtx = diag(16'h1000);
        nrm_x = 16'h1000; nrm_y = 16'h0800; nrm_z = 16'h0400;
        base_rgbc = 32'h11FF_FFFF; far_col = {32'h400, 32'h200, 32'h100}; sf = 1'b1;
        depth_ir0 = 16'h7000; go();
        depth_ir0 = 16'h8001; go();

        // R2 start while busy is ignored
        d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        check("R2", "single done", longint'(done_cnt - d0), 1);

        // random register sets
        for (int r = 0; r < 24; r++) begin
            for (int k = 0; k < 9; k++) begin
                light_mtx[k*16 +: 16] = 16'($urandom);
                color_mtx[k*16 +: 16] = 16'($urandom);
            end
            for (int k = 0; k < 3; k++) begin
                back_col[k*32 +: 32] = (r % 3 == 0) ? $urandom : ($urandom & 32'h0000_FFFF);
                far_col[k*32 +: 32]  = (r % 4 == 0) ? $urandom : ($urandom & 32'h0000_0FFF);
            end
            nrm_x = 16'($urandom); nrm_y = 16'($urandom); nrm_z = 16'($urandom);
            base_rgbc = $urandom; depth_ir0 = 16'($urandom);
            sf = 1'($urandom); lm = 1'($urandom);
            go();
        end
        finish_run();
    end
endmodule